// File: doc/BRIEF.md
# Configuration Unlock Sequencer with Relocatable Index/Data Window

This block watches writes on a simple I/O bus with a 16-bit address, 8-bit data and one-cycle read and write strobes. It waits for a five-write key sequence aimed at two fixed port addresses, 0x02FA (the low key port) and 0x03FA (the high key port). The fourth write of that sequence picks a base byte. When the sequence completes, the block opens a two-port configuration window. The index port sits at the base byte times four, and the data port sits at the next address.

While the window is open, software selects a register by writing to the index port. It then reads or writes that register through the data port. The register file has fifteen entries. Index 0xF is reserved: reading it returns the base byte, and writing it closes the window. A parameter selects between two key variants, which differ only in the first two writes. The outputs are a configuration-mode flag and the whole register file, so neighbouring decoders can use the settings.

Top module: `cfgseq_top`

## Requirements
- R1: A synchronous active-low reset clears configuration mode and loads the register defaults. For VARIANT_B=1 the defaults are entry 3=0xB0, 4=0xFE, 5=0xBE, 6=0x9E, 7=0x80 and 8=0xEC, with all others 0x00. For VARIANT_B=0 they are entry 0=0x0C, 4=0xFE, 6=0x9E, 9=0xB0 and 12=0xA0, with all others 0x00. The current index keeps its value through reset.
- R2: With VARIANT_B=0 the key sequence is five writes, in this order:
  - 0x55 to 0x02FA;
  - 0xAA to 0x03FA;
  - 0x36 to 0x03FA;
  - any byte X to 0x03FA;
  - a byte to 0x02FA whose bitwise OR with X is 0xFF.
- R3: With VARIANT_B=1 the sequence starts with a write to 0x02FA of any byte other than 0x00 or 0xFF, and the block stores that byte. The next write must go to 0x03FA and, ORed with the stored byte, must give 0xFF. The last three writes are the same as in R2.
- R4: Any write strobe that does not advance the sequence returns the sequencer to its first step, and this includes a write to any other address. The sequencer takes at most one step per strobe.
- R5: A correct last write sets configuration mode, places the index port at X*4 and places the data port at X*4+1. A last write to 0x02FA that fails the OR test clears configuration mode.
- R6: In configuration mode, a write to the index port stores data bits [3:0] as the current index. A read of the index port returns the index, zero-extended to 8 bits.
- R7: In configuration mode, a data-port write with an index from 0 to 14 updates that entry. A data-port read returns it. Entry i appears on cfg_regs[8*i+7:8*i].
- R8: With index 0xF, a data-port read returns X, and a data-port write clears configuration mode.
- R9: Outside configuration mode, every read returns 0xFF, and writes to the former window addresses leave the register file unchanged.
- R10: io_rdata is updated on the clock edge that samples io_rd high and holds its value otherwise. It resets to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Bus address |
| io_wdata | input | 8 | Bus write data |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_rdata | output | 8 | Registered read data |
| cfg_mode | output | 1 | High while the configuration window is open |
| cfg_regs | output | 120 | Register file; entry i at bits [8i+7:8i] |

## Verification
Every result is due on the edge that samples its strobe:
- a write to the last key step, the index port or the data port changes cfg_mode, the index or cfg_regs on that edge;
- a read loads io_rdata on the edge that samples io_rd.

The bench drives the bus 1 ns after a rising edge and keeps each strobe high for exactly one edge. It compares state one cycle later and compares read data at the falling edge after the capturing edge. Read expectations are queued by the driver and taken off the queue by a monitor that follows the strobe it saw.

// File: rtl/cfgseq_pkg.sv
// Shared constants, the sequencer state type and the reset defaults of the
// register file. Assumes an 8-bit data path and a 4-bit register index.
package cfgseq_pkg;

    localparam logic [15:0] KEY_PORT_LO = 16'h02FA;
    localparam logic [15:0] KEY_PORT_HI = 16'h03FA;
    localparam logic [7:0]  KEY_A_FIRST = 8'h55;
    localparam logic [7:0]  KEY_A_SECOND = 8'hAA;
    localparam logic [7:0]  KEY_COMMAND = 8'h36;
    localparam logic [3:0]  EXIT_INDEX = 4'hF;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_KEY1,
        SEQ_KEY2,
        SEQ_BASE,
        SEQ_LAST
    } seq_state_t;

    // Power-on value of one register-file entry for the chosen variant.
    function automatic logic [7:0] entry_default(input bit variant_b, input int idx);
        logic [7:0] v;
        v = 8'h00;
        if (variant_b) begin
            case (idx)
                3: v = 8'hB0;
                4: v = 8'hFE;
                5: v = 8'hBE;
                6: v = 8'h9E;
                7: v = 8'h80;
                8: v = 8'hEC;
                default: v = 8'h00;
            endcase
        end else begin
            case (idx)
                0:  v = 8'h0C;
                4:  v = 8'hFE;
                6:  v = 8'h9E;
                9:  v = 8'hB0;
                12: v = 8'hA0;
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/cfgseq_unlock.sv
// Key-sequence tracker. Follows the five-write unlock order across the two
// key ports and pulses open_pulse or close_pulse on the final step.
// Assumes wr_stb is one cycle wide per bus write.
// The stored key byte has no reset on purpose.
module cfgseq_unlock
    import cfgseq_pkg::*;
#(
    parameter bit VARIANT_B = 1'b1,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              open_pulse,
    output logic              close_pulse,
    output logic [DATA_W-1:0] key_byte
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [DATA_W-1:0] key_q;
    logic              store_key;
    logic              first_ok;
    logic              second_ok;
    logic              hit_lo;
    logic              hit_hi;

    assign hit_lo   = (addr == ADDR_W'(KEY_PORT_LO));
    assign hit_hi   = (addr == ADDR_W'(KEY_PORT_HI));
    assign key_byte = key_q;

    // The variant picks how the first two key writes are judged.
    generate
        if (VARIANT_B) begin : g_key_any
            assign first_ok  = (wdata != '0) && (wdata != ALL_ONES);
            assign second_ok = ((wdata | key_q) == ALL_ONES);
        end else begin : g_key_fixed
            assign first_ok  = (wdata == DATA_W'(KEY_A_FIRST));
            assign second_ok = (wdata == DATA_W'(KEY_A_SECOND));
        end
    endgenerate

    // Next-state and final-step decision for one write strobe.
    always_comb begin
        state_d     = state_q;
        store_key   = 1'b0;
        open_pulse  = 1'b0;
        close_pulse = 1'b0;
        if (wr_stb) begin
            state_d = SEQ_IDLE;
            case (state_q)
                SEQ_IDLE: if (hit_lo && first_ok) begin
                    state_d   = SEQ_KEY1;
                    store_key = VARIANT_B;
                end
                SEQ_KEY1: if (hit_hi && second_ok) state_d = SEQ_KEY2;
                SEQ_KEY2: if (hit_hi && wdata == DATA_W'(KEY_COMMAND)) state_d = SEQ_BASE;
                SEQ_BASE: if (hit_hi) begin
                    state_d   = SEQ_LAST;
                    store_key = 1'b1;
                end
                SEQ_LAST: if (hit_lo) begin
                    open_pulse  = ((wdata | key_q) == ALL_ONES);
                    close_pulse = ((wdata | key_q) != ALL_ONES);
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Key byte capture; survives reset.
    always_ff @(posedge clk) begin
        if (store_key) key_q <= wdata;
    end

endmodule

// File: rtl/cfgseq_regs.sv
// Configuration register file. One register per entry, reset to the variant
// defaults. Assumes at most one write per cycle, selected by widx.
module cfgseq_regs
    import cfgseq_pkg::*;
#(
    parameter bit VARIANT_B = 1'b1,
    parameter int REG_COUNT = 15,
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [REG_COUNT*DATA_W-1:0] flat
);

    generate
        for (genvar i = 0; i < REG_COUNT; i++) begin : g_entry
            logic [DATA_W-1:0] q;
            // Entry i: default on reset, load on an indexed write.
            always_ff @(posedge clk) begin
                if (!rst_n)                             q <= DATA_W'(entry_default(VARIANT_B, i));
                else if (we && widx == IDX_W'(i))       q <= wdata;
            end
            assign flat[i*DATA_W +: DATA_W] = q;
        end
    endgenerate

endmodule

// File: rtl/cfgseq_top.sv
// Unlock sequencer top. Opens an index/data window after a valid key
// sequence, serves register reads and writes through it, and closes it on
// the exit index. Assumes single-cycle io_wr and io_rd strobes.
module cfgseq_top
    import cfgseq_pkg::*;
#(
    parameter bit VARIANT_B = 1'b1,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 15,
    parameter int IDX_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           io_addr,
    input  logic [DATA_W-1:0]           io_wdata,
    input  logic                        io_wr,
    input  logic                        io_rd,
    output logic [DATA_W-1:0]           io_rdata,
    output logic                        cfg_mode,
    output logic [REG_COUNT*DATA_W-1:0] cfg_regs
);

    localparam logic [IDX_W-1:0] EXIT_IDX = IDX_W'(EXIT_INDEX);

    logic              open_pulse;
    logic              close_pulse;
    logic [DATA_W-1:0] key_byte;
    logic [ADDR_W-1:0] win_base_q;
    logic [IDX_W-1:0]  idx_q;
    logic              mode_q;
    logic              hit_idx;
    logic              hit_data;
    logic              exit_req;
    logic              reg_we;
    logic [DATA_W-1:0] reg_rd;
    logic [DATA_W-1:0] rd_next;

    cfgseq_unlock #(
        .VARIANT_B (VARIANT_B),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_unlock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (io_wr),
        .addr        (io_addr),
        .wdata       (io_wdata),
        .open_pulse  (open_pulse),
        .close_pulse (close_pulse),
        .key_byte    (key_byte)
    );

    assign hit_idx  = mode_q && (io_addr == win_base_q);
    assign hit_data = mode_q && (io_addr == win_base_q + ADDR_W'(1));
    assign exit_req = io_wr && hit_data && (idx_q == EXIT_IDX);
    assign reg_we   = io_wr && hit_data && (idx_q != EXIT_IDX);

    cfgseq_regs #(
        .VARIANT_B (VARIANT_B),
        .REG_COUNT (REG_COUNT),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .widx  (idx_q),
        .wdata (io_wdata),
        .flat  (cfg_regs)
    );

    // Configuration-mode flag; the key sequence wins over an exit write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mode_q <= 1'b0;
        else if (open_pulse)              mode_q <= 1'b1;
        else if (close_pulse || exit_req) mode_q <= 1'b0;
    end

    // Window base, taken from the key byte when the window opens.
    always_ff @(posedge clk) begin
        if (open_pulse) win_base_q <= ADDR_W'({key_byte, 2'b00});
    end

    // Current index; survives reset.
    always_ff @(posedge clk) begin
        if (io_wr && hit_idx) idx_q <= io_wdata[IDX_W-1:0];
    end

    // Register-file read mux by current index.
    always_comb begin
        reg_rd = '1;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (idx_q == IDX_W'(i)) reg_rd = cfg_regs[i*DATA_W +: DATA_W];
        end
    end

    // Read value selection for the window ports.
    always_comb begin
        rd_next = '1;
        if (hit_idx)                           rd_next = DATA_W'(idx_q);
        else if (hit_data && idx_q == EXIT_IDX) rd_next = win_base_q[DATA_W+1:2];
        else if (hit_data)                     rd_next = reg_rd;
    end

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     io_rdata <= '1;
        else if (io_rd) io_rdata <= rd_next;
    end

    assign cfg_mode = mode_q;

endmodule

// File: rtl/cfgseq_checker.sv
// Property checker for cfgseq_top, attached by bind. Observes ports plus the
// window base and index registers.
module cfgseq_checker #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 15,
    parameter int IDX_W     = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           io_addr,
    input logic [DATA_W-1:0]           io_wdata,
    input logic                        io_wr,
    input logic                        io_rd,
    input logic [DATA_W-1:0]           io_rdata,
    input logic                        cfg_mode,
    input logic [REG_COUNT*DATA_W-1:0] cfg_regs,
    input logic [ADDR_W-1:0]           win_base,
    input logic [IDX_W-1:0]            idx
);

    // R9: closed window reads give all ones.
    a_r9_read_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !cfg_mode) |=> (io_rdata == '1));

    // R9: register file frozen while closed.
    a_r9_regs_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable(cfg_regs));

    // R5: window opens only on a write to the low key port.
    a_r5_open_on_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> ($past(io_wr) && $past(io_addr) == ADDR_W'(16'h02FA)));

    // R8: exit index write on the data port closes the window.
    a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_wr && io_addr == win_base + ADDR_W'(1) && idx == '1
         && io_addr != ADDR_W'(16'h02FA)) |=> !cfg_mode);

    // R6: index port write loads the low data bits.
    a_r6_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_wr && io_addr == win_base) |=> (idx == $past(io_wdata[IDX_W-1:0])));

    // R10: read data holds without a read strobe.
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

endmodule

bind cfgseq_top cfgseq_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT),
    .IDX_W     (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .cfg_mode (cfg_mode),
    .cfg_regs (cfg_regs),
    .win_base (win_base_q),
    .idx      (idx_q)
);

// File: tb/sim_cfgseq_top.sv
// Scoreboard bench: u0 uses the any-byte key variant and u1 the fixed-key
// variant. Both share one bus.
module sim_cfgseq_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [15:0]  io_addr;
    logic [7:0]   io_wdata;
    logic         io_wr;
    logic         io_rd;
    logic [7:0]   rdata_b, rdata_a;
    logic         mode_b, mode_a;
    logic [119:0] regs_b, regs_a;

    always #5 clk = ~clk;

    cfgseq_top #(.VARIANT_B(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(rdata_b), .cfg_mode(mode_b),
        .cfg_regs(regs_b));

    cfgseq_top #(.VARIANT_B(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(rdata_a), .cfg_mode(mode_a),
        .cfg_regs(regs_a));

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         on_a;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t rdq[$];
    logic     rd_seen = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input bit on_a, input logic [7:0] exp,
                          input string tag);
        rd_item_t it;
        @(posedge clk); #1;
        io_addr = a; io_rd = 1'b1;
        it.on_a = on_a; it.exp = exp; it.tag = tag;
        rdq.push_back(it);
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic key_seq(input logic [7:0] k0, input logic [7:0] k1,
                           input logic [7:0] x, input logic [7:0] last);
        bus_wr(16'h02FA, k0);
        bus_wr(16'h03FA, k1);
        bus_wr(16'h03FA, 8'h36);
        bus_wr(16'h03FA, x);
        bus_wr(16'h02FA, last);
    endtask

    // Monitor: note the read strobe at the capturing edge.
    always @(posedge clk) rd_seen <= io_rd;

    // Monitor: compare the read data one half cycle after capture.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (rdq.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 unexpected read actual=%0h expected=none", rdata_b);
            end else begin
                rd_item_t it;
                it = rdq.pop_front();
                check(it.tag, it.on_a ? rdata_a : rdata_b, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_addr = 16'h0000; io_wdata = 8'h00; io_wr = 1'b0; io_rd = 1'b0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 reset state
        check("R1 mode_b", mode_b, 0);
        check("R1 mode_a", mode_a, 0);
        check("R1 b reg3", regs_b[3*8 +: 8], 8'hB0);
        check("R1 b reg8", regs_b[8*8 +: 8], 8'hEC);
        check("R1 b reg5", regs_b[5*8 +: 8], 8'hBE);
        check("R1 a reg0", regs_a[0*8 +: 8], 8'h0C);
        check("R1 a reg12", regs_a[12*8 +: 8], 8'hA0);
        check("R10 rdata reset", rdata_b, 8'hFF);

        // R9 closed reads
        bus_rd(16'h02E1, 1'b0, 8'hFF, "R9 closed read b");
        bus_rd(16'h02FA, 1'b1, 8'hFF, "R9 closed read a");

        // R3: any-byte key opens u0 at 0x2E0; R2: u1 rejects it
        key_seq(8'h12, 8'hED, 8'hB8, 8'h47);
        check("R3 b opened", mode_b, 1);
        check("R2 a stays closed", mode_a, 0);

        // R6 index, R7 data
        bus_wr(16'h02E0, 8'h35);
        bus_rd(16'h02E0, 1'b0, 8'h05, "R6 index readback");
        bus_wr(16'h02E1, 8'h5A);
        check("R7 b reg5 written", regs_b[5*8 +: 8], 8'h5A);
        bus_rd(16'h02E1, 1'b0, 8'h5A, "R7 data readback");
        bus_wr(16'h02E0, 8'h0E);
        bus_wr(16'h02E1, 8'h77);
        check("R7 b reg14 written", regs_b[14*8 +: 8], 8'h77);

        // R8 exit index
        bus_wr(16'h02E0, 8'hFF);
        bus_rd(16'h02E1, 1'b0, 8'hB8, "R8 base readback");
        bus_wr(16'h02E1, 8'h00);
        check("R8 b closed", mode_b, 0);

        // R9 closed window ignores writes
        bus_rd(16'h02E1, 1'b0, 8'hFF, "R9 read after exit");
        bus_wr(16'h02E0, 8'h05);
        bus_wr(16'h02E1, 8'h99);
        check("R9 b reg5 unchanged", regs_b[5*8 +: 8], 8'h5A);

        // R2 fixed key opens both at 0x0F0
        key_seq(8'h55, 8'hAA, 8'h3C, 8'hC3);
        check("R2 a opened", mode_a, 1);
        check("R5 b opened", mode_b, 1);
        bus_wr(16'h00F0, 8'h02);
        bus_wr(16'h00F1, 8'h11);
        check("R7 a reg2", regs_a[2*8 +: 8], 8'h11);
        bus_rd(16'h00F1, 1'b1, 8'h11, "R7 a data readback");
        bus_wr(16'h00F0, 8'h0F);
        bus_rd(16'h00F1, 1'b1, 8'h3C, "R8 a base readback");

        // R5 failed last step closes the window
        key_seq(8'h55, 8'hAA, 8'h3C, 8'h00);
        check("R5 a closed by bad last", mode_a, 0);
        check("R5 b closed by bad last", mode_b, 0);

        // R4 a stray write breaks the sequence
        bus_wr(16'h02FA, 8'h55);
        bus_wr(16'h03FA, 8'hAA);
        bus_wr(16'h0300, 8'h36);
        bus_wr(16'h03FA, 8'h36);
        bus_wr(16'h03FA, 8'h3C);
        bus_wr(16'h02FA, 8'hC3);
        check("R4 a not opened", mode_a, 0);
        check("R4 b not opened", mode_b, 0);
        bus_wr(16'h0300, 8'h00);   // return u0 to its first step

        // R1 index survives reset
        key_seq(8'h55, 8'hAA, 8'h3C, 8'hC3);
        bus_wr(16'h00F0, 8'h07);
        @(posedge clk); #1; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        check("R1 a closed after reset", mode_a, 0);
        check("R1 a reg2 default", regs_a[2*8 +: 8], 8'h00);
        check("R1 b reg5 default", regs_b[5*8 +: 8], 8'hBE);
        key_seq(8'h55, 8'hAA, 8'h3C, 8'hC3);
        bus_rd(16'h00F0, 1'b0, 8'h07, "R1 b index kept");
        bus_rd(16'h00F0, 1'b1, 8'h07, "R1 a index kept");

        repeat (3) @(posedge clk);
        check("R10 scoreboard drained", rdq.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule